// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers a set of level-sensitive interrupt request lines and drives one interrupt line towards a processor. When the processor pulses its acknowledge input, the controller picks the winning request and moves it from pending to in-service. One cycle later it returns a vector equal to a programmable base plus the winning line index. A line stays in service until software writes an end-of-interrupt command. That command either names a line or clears whichever in-service line currently has the highest priority.

Priority is either fixed or rotating. In fixed mode, line 0 is highest and the last line is lowest. In rotating mode, the line that an end-of-interrupt closes becomes the lowest, and the line after it becomes the highest. A mask register suppresses chosen lines. A small register port covers the mask, the vector base, the mode, the end-of-interrupt command, and reads of the pending and in-service state.

Register map (3-bit address, 8-bit data):

| Address | Write | Read |
|---|---|---|
| 0 | mask, bit i masks line i | mask |
| 1 | vector base | vector base |
| 2 | bit 0 selects rotating mode; any write puts the last line back as lowest | mode |
| 3 | end-of-interrupt: bit 7 = 1 clears the line in bits [2:0], bit 7 = 0 clears the highest-priority in-service line | in-service |
| 4 | ignored | pending |

Top module: `pic_ctrl`

## Requirements
- R1: After reset, the registers read as follows: mask 0xFF, pending 0x00, in-service 0x00, mode 0. The interrupt output is low.
- R2: In fixed mode, the lower line index wins. The cycle after an acknowledge, vec_valid_o pulses and vec_o equals base + index of the winner.
- R3: An acknowledge that grants a line sets that line's in-service bit and clears its pending bit. The pending bit reads as clear in the cycle after the acknowledge. In-service grows by at most one line per cycle.
- R4: A masked line never raises irq_o and is never granted. Acknowledging while only masked lines are pending returns the spurious vector 0xFF.
- R5: irq_o is high only when an unmasked pending line has strictly higher priority than every in-service line.
- R6: An end-of-interrupt write with bit 7 = 0 clears only the highest-priority set in-service bit.
- R7: An end-of-interrupt write with bit 7 = 1 clears the in-service bit of the line given in bits [2:0].
- R8: In rotating mode, an end-of-interrupt for line k makes line k+1 (mod 8) the highest priority and line k the lowest.
- R9: Requests are level-sensitive. A request that drops before it is acknowledged leaves the pending register.
- R10: An acknowledge with no qualifying request returns vector 0xFF and leaves in-service unchanged.
- R11: Writes to address 4 have no effect on the pending register.
- R12: A line that stays high after its grant shows pending again while still in service, so that line has two outstanding events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Level interrupt requests, asynchronous |
| irq_o | output | 1 | Interrupt to the processor |
| ack_i | input | 1 | Acknowledge pulse, one cycle |
| vec_o | output | 8 | Vector returned for the last acknowledge |
| vec_valid_o | output | 1 | One-cycle pulse when vec_o is fresh |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational |

## Verification
Faults in the in-service register show up in two ways. A wrong bit blocks or unblocks irq_o as soon as the next request settles. It also changes which line a non-specific end-of-interrupt closes, and that is visible on the next in-service read. A corrupt rotation pointer stays hidden until two lines compete. The bench therefore sets up contests in rotating mode, and a bad pointer shows as a wrong vector on the very next acknowledge. Pending-register errors appear within the synchronizer latency plus one cycle, because reads expose that register directly.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [2:0] {
    ADDR_MASK = 3'd0,
    ADDR_BASE = 3'd1,
    ADDR_MODE = 3'd2,
    ADDR_EOI  = 3'd3,
    ADDR_PEND = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/pic_sync.sv
module pic_sync #(
  parameter int N      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [STAGES-1:0][N-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pic_prio_find.sv
// Find first set bit, scanning upward from the line after low_i (wrapping).
module pic_prio_find #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]   vec_i,
  input  logic [IDX_W-1:0] low_i,
  output logic           hit_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [IDX_W:0] rank_o
);
  always_comb begin
    int j;
    hit_o  = 1'b0;
    idx_o  = '0;
    rank_o = (IDX_W+1)'(N);
    for (int k = N - 1; k >= 0; k--) begin
      j = int'(low_i) + 1 + k;
      if (j >= N) j = j - N;
      if (vec_i[j]) begin
        hit_o  = 1'b1;
        idx_o  = IDX_W'(j);
        rank_o = (IDX_W+1)'(k);
      end
    end
  end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
#(
  parameter int          NUM_LINES   = 8,
  parameter int          DATA_W      = 8,
  parameter int          VEC_W       = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  SPUR_VEC    = 8'hFF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] req_i,
  output logic                 irq_o,
  input  logic                 ack_i,
  output logic [VEC_W-1:0]     vec_o,
  output logic                 vec_valid_o,
  input  logic                 reg_we_i,
  input  logic [2:0]           reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o
);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_LINES - 1);
  localparam logic [NUM_LINES-1:0] ONE = NUM_LINES'(1);

  logic [NUM_LINES-1:0] mask_q, irr_q, isr_q, req_sync;
  logic [VEC_W-1:0]     base_q, vec_q;
  logic                 rot_q, vval_q;
  logic [IDX_W-1:0]     low_q, low_eff;

  pic_sync #(.N(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_i),
    .q_o   (req_sync)
  );

  assign low_eff = rot_q ? low_q : LAST;

  logic                 req_hit, isr_hit;
  logic [IDX_W-1:0]     req_idx, isr_idx;
  logic [IDX_W:0]       req_rank, isr_rank;

  pic_prio_find #(.N(NUM_LINES), .IDX_W(IDX_W)) u_req_find (
    .vec_i (irr_q & ~mask_q),
    .low_i (low_eff),
    .hit_o (req_hit),
    .idx_o (req_idx),
    .rank_o(req_rank)
  );

  pic_prio_find #(.N(NUM_LINES), .IDX_W(IDX_W)) u_isr_find (
    .vec_i (isr_q),
    .low_i (low_eff),
    .hit_o (isr_hit),
    .idx_o (isr_idx),
    .rank_o(isr_rank)
  );

  // Strictly higher than any line in service (empty isr ranks as NUM_LINES).
  logic irq;
  assign irq   = req_hit && (req_rank < isr_rank);
  assign irq_o = irq;

  logic                 grant;
  logic [NUM_LINES-1:0] grant_vec;
  assign grant     = ack_i && irq;
  assign grant_vec = grant ? (ONE << req_idx) : '0;

  logic                 eoi_we, eoi_spec, eoi_ok;
  logic [IDX_W-1:0]     eoi_line;
  logic [NUM_LINES-1:0] eoi_clr;
  assign eoi_we   = reg_we_i && (reg_addr_i == ADDR_EOI);
  assign eoi_spec = reg_wdata_i[DATA_W-1];
  assign eoi_line = eoi_spec ? reg_wdata_i[IDX_W-1:0] : isr_idx;
  assign eoi_ok   = eoi_we && (eoi_spec || isr_hit);
  assign eoi_clr  = eoi_ok ? (ONE << eoi_line) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      base_q <= '0;
      rot_q  <= 1'b0;
      low_q  <= LAST;
      irr_q  <= '0;
      isr_q  <= '0;
      vec_q  <= '0;
      vval_q <= 1'b0;
    end else begin
      irr_q  <= req_sync & ~grant_vec;
      isr_q  <= (isr_q & ~eoi_clr) | grant_vec;
      vval_q <= ack_i;
      if (ack_i) vec_q <= grant ? base_q + VEC_W'(req_idx) : VEC_W'(SPUR_VEC);
      if (reg_we_i) begin
        unique case (reg_addr_i)
          ADDR_MASK: mask_q <= reg_wdata_i[NUM_LINES-1:0];
          ADDR_BASE: base_q <= reg_wdata_i[VEC_W-1:0];
          ADDR_MODE: begin
            rot_q <= reg_wdata_i[0];
            low_q <= LAST;
          end
          ADDR_EOI:  if (eoi_ok && rot_q) low_q <= eoi_line;
          default: ;
        endcase
      end
    end
  end

  assign vec_o       = vec_q;
  assign vec_valid_o = vval_q;

  always_comb begin
    unique case (reg_addr_i)
      ADDR_MASK: reg_rdata_o = DATA_W'(mask_q);
      ADDR_BASE: reg_rdata_o = DATA_W'(base_q);
      ADDR_MODE: reg_rdata_o = DATA_W'(rot_q);
      ADDR_EOI:  reg_rdata_o = DATA_W'(isr_q);
      ADDR_PEND: reg_rdata_o = DATA_W'(irr_q);
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
  parameter int         NUM_LINES = 8,
  parameter int         VEC_W     = 8,
  parameter logic [7:0] SPUR_VEC  = 8'hFF
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 ack_i,
  input logic                 irq_o,
  input logic                 reg_we_i,
  input logic                 vec_valid_o,
  input logic [VEC_W-1:0]     vec_o,
  input logic [NUM_LINES-1:0] isr_i,
  input logic [NUM_LINES-1:0] irr_i,
  input logic [NUM_LINES-1:0] mask_i
);
  AST_IRQ_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((irr_i & ~mask_i) != '0)); // R4

  AST_MASK_NEVER_SERVED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> ((isr_i & ~$past(isr_i) & $past(mask_i)) == '0)); // R4

  AST_VALID_FROM_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> $past(ack_i)); // R2

  AST_GRANT_GIVES_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> (vec_valid_o && (vec_o != VEC_W'(SPUR_VEC)))); // R2

  AST_SPURIOUS_KEEPS_ISR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o && !reg_we_i) |=> $stable(isr_i)); // R10

  AST_ISR_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(isr_i) <= $countones($past(isr_i)) + 1); // R3
endmodule

bind pic_ctrl pic_checker #(
  .NUM_LINES(NUM_LINES),
  .VEC_W    (VEC_W),
  .SPUR_VEC (SPUR_VEC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ack_i      (ack_i),
  .irq_o      (irq_o),
  .reg_we_i   (reg_we_i),
  .vec_valid_o(vec_valid_o),
  .vec_o      (vec_o),
  .isr_i      (isr_q),
  .irr_i      (irr_q),
  .mask_i     (mask_q)
);

// File: tb/pic_ctrl_tb.sv
module pic_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0;
  logic       irq, ack = 1'b0, vval;
  logic [7:0] vec;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  pic_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .irq_o(irq), .ack_i(ack),
    .vec_o(vec), .vec_valid_o(vval), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  // {req, mask, expected vector}; base 0x40, fixed mode
  localparam logic [23:0] TBL [6] = '{
    {8'hA0, 8'h00, 8'h45},
    {8'h81, 8'h01, 8'h47},
    {8'h00, 8'h00, 8'hFF},
    {8'hFF, 8'hFE, 8'h40},
    {8'h0C, 8'h00, 8'h42},
    {8'h10, 8'h10, 8'hFF}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic do_ack(input string tag, input logic [7:0] exp);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    check({tag, " valid"}, {7'd0, vval}, 8'd1);
    check({tag, " vector"}, vec, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(3'd0, r); check("R1 mask", r, 8'hFF);
    rd(3'd4, r); check("R1 pending", r, 8'h00);
    rd(3'd3, r); check("R1 in-service", r, 8'h00);
    rd(3'd2, r); check("R1 mode", r, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    wr(3'd1, 8'h40);

    // R2 / R4 / R10 table walk
    for (int i = 0; i < 6; i++) begin
      wr(3'd0, TBL[i][15:8]);
      req = TBL[i][23:16];
      settle();
      check("R5 table irq", {7'd0, irq}, {7'd0, TBL[i][7:0] != 8'hFF});
      do_ack("R2 table", TBL[i][7:0]);
      if (TBL[i][7:0] != 8'hFF) wr(3'd3, 8'h00);
      req = '0;
      settle();
      rd(3'd3, r); check("R6 table isr cleared", r, 8'h00);
    end
    wr(3'd0, 8'h00);

    // R3 / R12
    req = 8'h08; settle();
    do_ack("R3 ack", 8'h43);
    rd(3'd4, r); check("R3 pending cleared", r, 8'h00);
    rd(3'd3, r); check("R3 in-service set", r, 8'h08);
    settle();
    rd(3'd4, r); check("R12 pending again", r, 8'h08);
    check("R5 equal blocked", {7'd0, irq}, 8'h00);
    // R5 lower and higher priority against line 3 in service
    req = 8'h28; settle();
    check("R5 lower blocked", {7'd0, irq}, 8'h00);
    req = 8'h2A; settle();
    check("R5 higher raises", {7'd0, irq}, 8'h01);
    do_ack("R5 nested", 8'h41);
    rd(3'd3, r); check("R5 nested isr", r, 8'h0A);
    // R6 non-specific
    wr(3'd3, 8'h00);
    rd(3'd3, r); check("R6 non-specific", r, 8'h08);
    // R7 specific
    wr(3'd3, 8'h83);
    rd(3'd3, r); check("R7 specific", r, 8'h00);
    settle();
    do_ack("R7 regrant", 8'h41);
    wr(3'd3, 8'h81);
    rd(3'd3, r); check("R7 specific line1", r, 8'h00);
    req = '0; settle();

    // R9 drop before ack, R10 spurious
    req = 8'h10; settle();
    rd(3'd4, r); check("R9 pending", r, 8'h10);
    req = '0; settle();
    rd(3'd4, r); check("R9 dropped", r, 8'h00);
    do_ack("R10 spurious", 8'hFF);
    rd(3'd3, r); check("R10 isr unchanged", r, 8'h00);

    // R11 pending not writable
    req = 8'h04; settle();
    wr(3'd4, 8'hFF);
    rd(3'd4, r); check("R11 pending write ignored", r, 8'h04);
    req = '0; settle();

    // R4 masked line
    wr(3'd0, 8'h04); req = 8'h04; settle();
    check("R4 masked irq", {7'd0, irq}, 8'h00);
    do_ack("R4 masked ack", 8'hFF);
    req = '0; wr(3'd0, 8'h00); settle();

    // R8 rotating
    wr(3'd2, 8'h01);
    req = 8'h08; settle();
    do_ack("R8 first", 8'h43);
    wr(3'd3, 8'h00);
    req = '0; settle();
    req = 8'h44; settle();
    do_ack("R8 after line3", 8'h46);
    wr(3'd3, 8'h00);
    req = 8'h04; settle();
    do_ack("R8 after line6", 8'h42);
    wr(3'd3, 8'h00);
    req = 8'h82; settle();
    do_ack("R8 after line2", 8'h47);
    wr(3'd3, 8'h00);
    req = '0; settle();
    // back to fixed
    wr(3'd2, 8'h00);
    req = 8'h82; settle();
    do_ack("R2 fixed again", 8'h41);
    wr(3'd3, 8'h00);
    req = '0; settle();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule